// File: doc/BRIEF.md
# Dual-Bus DDR Sample Splitter with Sync Realignment

This block accepts two 16-bit double-data-rate sample buses and turns them into four parallel 16-bit sample streams. Each bus time-multiplexes two channels. The first bus carries channel A on the rising clock edge and channel B on the falling edge. The second bus carries channel C on the rising edge and channel D on the falling edge. The rising-edge word is held until the following falling edge. On that falling edge the four words of the cycle form one entry, and the entry is written into an eight-entry circular buffer.

A sync input is sampled on the rising edge and realigns the buffer. The entry of the sync cycle is written at slot 0, and the read side restarts at slot 4. Every entry therefore leaves the buffer a fixed five rising edges after its A sample was taken. The sync may be a single pulse or a periodic signal. A periodic sync that lands on the slot the pointers already hold leaves the output stream untouched. The four outputs carry a common valid flag, which rises once the buffer holds data written since the last realignment.

Top module: `ddr_pair_capture`

## Requirements
- R1: The word on `rx_ab` at a rising edge appears on `ch_a`. The word on `rx_ab` at the following falling edge appears on `ch_b`. Both appear in the same cycle.
- R2: The word on `rx_cd` at a rising edge appears on `ch_c`. The word on `rx_cd` at the following falling edge appears on `ch_d`. Both appear in the same cycle as the A/B pair of that cycle.
- R3: Each word passes through with its bit order unchanged: input bit 0 goes to output bit 0, and bit 15 to bit 15.
- R4: The pair set whose rising-edge sample was taken at rising edge k is shown on the outputs from rising edge k+5 onward. Successive cycles come out in their arrival order.
- R5: A sync seen high at a rising edge forces a realignment, unless the block is already running with its pointers on the sync slot. A realignment clears `out_valid` at that same edge. `out_valid` stays low for four more edges and rises at the fifth edge after the sync. At that edge the outputs show the sync cycle's samples.
- R6: A periodic sync whose period is a multiple of eight cycles, counted from the last realignment, causes no realignment. `out_valid` stays high and the stream continues without a gap or a repeat.
- R7: After reset, `out_valid` stays low until a sync has been seen.
- R8: An active-low `rst_n` clears `out_valid` and all four channel outputs to zero at once, without waiting for a clock edge.
- R9: If sync stays high for several consecutive rising edges, the last of those edges sets the alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; both edges carry data |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_ab | input | 16 | Bus carrying channel A (rising edge) and channel B (falling edge) |
| rx_cd | input | 16 | Bus carrying channel C (rising edge) and channel D (falling edge) |
| sync_in | input | 1 | Realignment request, sampled on the rising edge |
| ch_a | output | 16 | Channel A sample |
| ch_b | output | 16 | Channel B sample |
| ch_c | output | 16 | Channel C sample |
| ch_d | output | 16 | Channel D sample |
| out_valid | output | 1 | All four channel outputs hold aligned data |

## Verification
Two events can fall in the same cycle: a sync, and a buffer write and read in full steady flow. Whether the sync disturbs the stream depends on where the pointers stand at that moment.

The bench applies syncs at three kinds of position, each while the output is already valid. Some land on the aligned slot. One lands off the slot. One stretches over two edges, so that the first edge realigns and the second realigns again one slot later. Each cycle it judges `out_valid` against a hand-written expectation. Whenever data is expected, it also compares all four channels with the words it drove five cycles earlier. This shows that aligned syncs leave no gap and that a misaligned sync resumes exactly on the sync cycle's samples.

// File: rtl/ddr_pair_capture.sv
module ddr_pair_capture #(
  parameter int W      = 16,
  parameter int DEPTH  = 8,
  parameter int RD_OFS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rx_ab,
  input  logic [W-1:0] rx_cd,
  input  logic         sync_in,
  output logic [W-1:0] ch_a,
  output logic [W-1:0] ch_b,
  output logic [W-1:0] ch_c,
  output logic [W-1:0] ch_d,
  output logic         out_valid
);
  localparam int PW  = $clog2(DEPTH);
  localparam int LAG = DEPTH - RD_OFS;
  localparam int CW  = $clog2(LAG + 1);

  logic [W-1:0]   rise_ab, rise_cd;
  logic           sync_q;
  logic [4*W-1:0] mem [DEPTH];
  logic [PW-1:0]  wptr, rptr, widx;
  logic           seen;
  logic [CW-1:0]  cnt;
  logic           aligned;

  assign widx    = sync_q ? '0 : wptr;
  assign aligned = seen && (wptr == '0) && (rptr == PW'(RD_OFS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_ab <= '0;
      rise_cd <= '0;
      sync_q  <= 1'b0;
    end else begin
      rise_ab <= rx_ab;
      rise_cd <= rx_cd;
      sync_q  <= sync_in;
    end
  end

  always_ff @(negedge clk) begin
    mem[widx] <= {rise_ab, rx_ab, rise_cd, rx_cd};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) wptr <= '0;
    else        wptr <= widx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      {ch_a, ch_b, ch_c, ch_d} <= '0;
    end else begin
      rptr <= sync_in ? PW'(RD_OFS) : rptr + 1'b1;
      {ch_a, ch_b, ch_c, ch_d} <= mem[rptr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else if (sync_in && !aligned) begin
      seen      <= 1'b1;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else if (seen && !out_valid) begin
      if (cnt == CW'(LAG)) out_valid <= 1'b1;
      else                 cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ddr_pair_capture_chk.sv
module ddr_pair_capture_chk #(
  parameter int PW     = 3,
  parameter int RD_OFS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_in,
  input logic          out_valid,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr
);
  logic sync_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_seen <= 1'b0;
    else        sync_seen <= sync_seen | sync_in;
  end

  a_r7_quiet_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_seen |-> !out_valid);

  a_r5_read_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> (rptr == PW'(RD_OFS)));

  a_r6_aligned_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && out_valid && wptr == '0 && rptr == PW'(RD_OFS - 1)) |=> out_valid);

  a_r4_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !sync_in) |=> out_valid);

  a_r5_misaligned_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && (wptr != '0)) |=> !out_valid);

  a_r8_reset_clears: assert property (@(posedge clk)
    !rst_n |-> !out_valid);
endmodule

bind ddr_pair_capture ddr_pair_capture_chk #(.PW(PW), .RD_OFS(RD_OFS)) i_chk (
  .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .out_valid(out_valid),
  .wptr(wptr), .rptr(rptr)
);

// File: tb/test_ddr_pair_capture.sv
module test_ddr_pair_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rx_ab = '0, rx_cd = '0;
  logic        sync_in = 1'b0;
  logic [15:0] ch_a, ch_b, ch_c, ch_d;
  logic        out_valid;

  int checks = 0, errors = 0, gj = 0;
  bit done = 0;
  logic [15:0] va [128], vb [128], vc [128], vd [128];

  localparam logic [47:0] SYNC_V = (48'd1 << 2) | (48'd1 << 10) | (48'd1 << 18) |
                                   (48'd1 << 23) | (48'd1 << 24) | (48'd1 << 32) |
                                   (48'd1 << 40);
  localparam logic [47:0] EXP_V  = ((48'd1 << 23) - (48'd1 << 7)) | ~((48'd1 << 29) - 48'd1);

  always #10 clk = ~clk;

  ddr_pair_capture i_ddr_pair_capture (
    .clk(clk), .rst_n(rst_n), .rx_ab(rx_ab), .rx_cd(rx_cd), .sync_in(sync_in),
    .ch_a(ch_a), .ch_b(ch_b), .ch_c(ch_c), .ch_d(ch_d), .out_valid(out_valid)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, gj, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic ev, input string vtag,
                     input logic [15:0] a, input logic [15:0] b,
                     input logic [15:0] c, input logic [15:0] d);
    va[gj] = a; vb[gj] = b; vc[gj] = c; vd[gj] = d;
    rx_ab = a; rx_cd = c; sync_in = s;
    @(posedge clk); #5;
    rx_ab = b; rx_cd = d; sync_in = 1'b0;
    @(negedge clk); #1;
    chk(vtag, {15'd0, out_valid}, {15'd0, ev});
    if (ev && gj >= 5) begin
      chk("R1 ch_a", ch_a, va[gj-5]);
      chk("R1 ch_b", ch_b, vb[gj-5]);
      chk("R2 ch_c", ch_c, vc[gj-5]);
      chk("R2 ch_d", ch_d, vd[gj-5]);
    end
    gj++;
  endtask

  function automatic logic [15:0] dat(input int ch, input int k);
    return 16'(k * 16'h0123 + ch * 16'h1111) ^ 16'hA55A;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R8 reset valid", {15'd0, out_valid}, 16'd0);
    chk("R8 reset ch_a", ch_a, 16'd0);
    chk("R8 reset ch_d", ch_d, 16'd0);
    rst_n = 1'b1;

    for (int j = 0; j < 48; j++)
      cyc(SYNC_V[j], EXP_V[j], "R4 R5 R6 R7 R9 valid",
          dat(0, j), dat(1, j), dat(2, j), dat(3, j));

    rst_n = 1'b0; #2;
    chk("R8 async valid", {15'd0, out_valid}, 16'd0);
    chk("R8 async ch_b", ch_b, 16'd0);
    chk("R8 async ch_c", ch_c, 16'd0);
    @(negedge clk); #1;
    rst_n = 1'b1;

    for (int j = 0; j < 10; j++)
      cyc(1'b0, 1'b0, "R7 no sync", dat(0, j + 60), dat(1, j + 60), dat(2, j + 60), dat(3, j + 60));

    cyc(1'b1, 1'b0, "R5 sync edge", 16'h8001, 16'h4002, 16'h0180, 16'h7FFE);
    for (int j = 0; j < 4; j++)
      cyc(1'b0, 1'b0, "R4 latency low", dat(0, j + 80), dat(1, j + 80), dat(2, j + 80), dat(3, j + 80));
    cyc(1'b0, 1'b1, "R4 latency high", 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0);
    chk("R3 bit order a", ch_a, 16'h8001);
    chk("R3 bit order b", ch_b, 16'h4002);
    chk("R3 bit order c", ch_c, 16'h0180);
    chk("R3 bit order d", ch_d, 16'h7FFE);
    for (int j = 0; j < 3; j++)
      cyc(1'b0, 1'b1, "R4 continue", dat(0, j + 90), dat(1, j + 90), dat(2, j + 90), dat(3, j + 90));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule